// File: doc/BRIEF.md
# Host Register Bus Slave

This block lets a host processor reach a bank of 32-bit registers over an asynchronous parallel bus. The host asserts an active-low select together with a read/write level, an address, write data and active-low byte-lane enables. The block brings the select and the direction level into its own clock domain. After a fixed delay it pulls an active-low ready handshake low. The host then releases the select. The ready line is modelled as an open-drain pin with an external pull-up: an enable output and a data output stand in for the pin. Before the enable is removed, the data output is driven high for exactly one cycle.

A static mode input selects the bus width. In 32-bit mode, each of the four byte lanes is written only when its enable is low. In 16-bit mode, the host moves half-words. The lowest address bit picks the half of the register, the two lowest enables pick bytes within that half, and the two upper enables have no effect. Register 0 is a control register that shapes two active-low interrupt outputs. Each output stands for one group of request lines. The two outputs can be merged into one, and each can be held inactive.

Top module: `host_regbus_slave`

## Requirements
- R1: While reset is asserted and right after it, rdy_n_o is 1, rdy_oe_o is 0, rdata_o is 0, irq_n_o is 2'b11, and every register, including control, reads as 0.
- R2: When cs_n_i falls between two rising edges, rdy_n_o goes to 0 and rdy_oe_o goes to 1 on rising edge number 3+READY_DLY after that fall (the 5th with default parameters). Every access, read or write, takes effect at that same edge.
- R3: When cs_n_i rises while ready is low, the 3rd rising edge after the rise sets rdy_n_o to 1 with rdy_oe_o still 1. The 4th edge clears rdy_oe_o. rdy_oe_o never falls unless rdy_n_o was 1 in the cycle before.
- R4: In 32-bit mode (mode32_i=1), the register index is addr_i. Byte k (bits 8k+7..8k) is written from wdata_i only when be_n_i[k]=0. When be_n_i[k]=1, that byte keeps its old value.
- R5: In 16-bit mode (mode32_i=0), the register index is addr_i[ADDR_W-1:1], and addr_i[0]=1 selects bits 31..16 (0 selects bits 15..0). wdata_i[15:0] goes to the selected half: be_n_i[0] gates its low byte and be_n_i[1] gates its high byte. be_n_i[3:2] are ignored. A read returns the selected half on rdata_o[15:0], with rdata_o[31:16]=0.
- R6: rdata_o carries the read result exactly while rdy_n_o is 0, stays unchanged for that whole time, and is 0 at every other time, including during write accesses.
- R7: A register index of NUM_REGS or above reads as 0. A write to it changes no register, and the access still completes the full handshake of R2 and R3.
- R8: Register 0 holds the control bits: bit 0 merge, bit 1 quiet-0 and bit 2 quiet-1. All its other bits read 0.
- R9: irq_n_o[0] is 0 when any req_a_i bit is 1, or when merge=1 and any req_b_i bit is 1. Otherwise it is 1. Interrupt outputs follow the inputs and control bits as they stood at the previous rising edge.
- R10: irq_n_o[1] is 0 only when any req_b_i bit is 1 and merge=0. With merge=1 it stays 1.
- R11: With quiet-0=1, irq_n_o[0] is 1 whatever the requests are. With quiet-1=1, irq_n_o[1] is 1 whatever the requests are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode32_i | input | 1 | Static bus width: 1 = 32-bit, 0 = 16-bit |
| cs_n_i | input | 1 | Active-low select from the host (asynchronous) |
| rd_wr_i | input | 1 | Direction: 1 = read, 0 = write (asynchronous) |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | 32 | Write data (16-bit mode uses bits 15..0) |
| be_n_i | input | 4 | Active-low byte-lane write enables |
| rdata_o | output | 32 | Read data, valid while ready is low |
| rdy_n_o | output | 1 | Ready pin data value (active low) |
| rdy_oe_o | output | 1 | Ready pin drive enable; 0 means pulled up |
| req_a_i | input | A_W | Interrupt requests of group A |
| req_b_i | input | B_W | Interrupt requests of group B |
| irq_n_o | output | 2 | Active-low interrupt outputs |

## Verification
On every cycle, the assertions check the pin-driving rules of the ready line: it is never low while undriven, it rises only while driven, and the drive is removed only after a driven-high cycle. They also check that read data is zero outside the ready window and steady inside it, and that the merge and quiet bits keep their interrupt outputs inactive. The exact ready latency, the byte-lane merge, the half-word mapping, unmapped addresses and the masking of the control register can be shown only by the bench's access sequences. The bench compares these against its cycle-level model and against hand-computed read-back values.

// File: rtl/host_regbus_pkg.sv
package host_regbus_pkg;
    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_WAIT = 2'd1,
        HS_ACK  = 2'd2,
        HS_REL  = 2'd3
    } hs_state_e;

    localparam int CTRL_W = 3;

    typedef struct packed {
        logic quiet1;
        logic quiet0;
        logic merge;
    } irq_ctrl_t;
endpackage

// File: rtl/host_regbus_sync.sv
module host_regbus_sync #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = d_i;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '{stage1: RST_VAL, stage2: RST_VAL};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign q_o = sync_q.stage2;
endmodule

// File: rtl/host_regbus_hs.sv
module host_regbus_hs
    import host_regbus_pkg::*;
#(
    parameter int READY_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s_i,
    output logic commit_o,
    output logic ack_o,
    output logic rdy_n_o,
    output logic rdy_oe_o
);
    localparam int CNT_W = (READY_DLY > 1) ? $clog2(READY_DLY) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(READY_DLY - 1);

    typedef struct packed {
        hs_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             rdy_n;
        logic             rdy_oe;
    } hs_t;

    hs_t hs_d, hs_q;
    logic commit_d;

    always_comb begin
        hs_d     = hs_q;
        commit_d = 1'b0;
        unique case (hs_q.st)
            HS_IDLE: begin
                if (!cs_s_i) begin
                    hs_d.st  = HS_WAIT;
                    hs_d.cnt = '0;
                end
            end
            HS_WAIT: begin
                if (hs_q.cnt == CNT_LAST) begin
                    hs_d.st  = HS_ACK;
                    commit_d = 1'b1;
                end else begin
                    hs_d.cnt = hs_q.cnt + 1'b1;
                end
            end
            HS_ACK: begin
                if (cs_s_i) begin
                    hs_d.st = HS_REL;
                end
            end
            HS_REL: begin
                hs_d.st = HS_IDLE;
            end
            default: hs_d.st = HS_IDLE;
        endcase
        hs_d.rdy_n  = (hs_d.st != HS_ACK);
        hs_d.rdy_oe = (hs_d.st == HS_ACK) || (hs_d.st == HS_REL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= '{st: HS_IDLE, cnt: '0, rdy_n: 1'b1, rdy_oe: 1'b0};
        end else begin
            hs_q <= hs_d;
        end
    end

    assign commit_o = commit_d;
    assign ack_o    = (hs_q.st == HS_ACK);
    assign rdy_n_o  = hs_q.rdy_n;
    assign rdy_oe_o = hs_q.rdy_oe;
endmodule

// File: rtl/host_regbus_bank.sv
module host_regbus_bank
    import host_regbus_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode32_i,
    input  logic              commit_i,
    input  logic              is_read_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic [3:0]        be_n_i,
    output logic [31:0]       rdata_o,
    output irq_ctrl_t         ctrl_o
);
    localparam int          LANES     = 4;
    localparam logic [31:0] CTRL_MASK = 32'((64'd1 << CTRL_W) - 64'd1);

    typedef struct packed {
        logic [NUM_REGS-1:0][31:0] regs;
        logic [31:0]               rdata;
    } bank_t;

    bank_t bank_d, bank_q;

    logic [ADDR_W-1:0] idx;
    logic [31:0]       idx32;
    logic              upper_half;
    logic [LANES-1:0]  lane_en;
    logic [31:0]       wd_aligned;
    logic [31:0]       word;
    logic [31:0]       rd_sel;

    // Lane decode: 32-bit mode honours all enables, 16-bit mode maps the
    // two low enables onto the addressed half and ignores the upper pair.
    always_comb begin
        upper_half = addr_i[0];
        if (mode32_i) begin
            idx        = addr_i;
            lane_en    = ~be_n_i;
            wd_aligned = wdata_i;
        end else begin
            idx        = {1'b0, addr_i[ADDR_W-1:1]};
            lane_en    = upper_half ? {~be_n_i[1:0], 2'b00} : {2'b00, ~be_n_i[1:0]};
            wd_aligned = {wdata_i[15:0], wdata_i[15:0]};
        end
        idx32 = 32'(idx);
    end

    always_comb begin
        word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx32 == 32'(i)) begin
                word = bank_q.regs[i];
            end
        end
        if (mode32_i) begin
            rd_sel = word;
        end else if (upper_half) begin
            rd_sel = {16'h0000, word[31:16]};
        end else begin
            rd_sel = {16'h0000, word[15:0]};
        end
    end

    always_comb begin
        bank_d = bank_q;
        if (commit_i) begin
            if (is_read_i) begin
                bank_d.rdata = rd_sel;
            end else begin
                bank_d.rdata = '0;
                for (int i = 0; i < NUM_REGS; i++) begin
                    if (idx32 == 32'(i)) begin
                        for (int b = 0; b < LANES; b++) begin
                            if (lane_en[b]) begin
                                bank_d.regs[i][8*b +: 8] = wd_aligned[8*b +: 8];
                            end
                        end
                    end
                end
            end
        end
        bank_d.regs[0] = bank_d.regs[0] & CTRL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rdata_o = bank_q.rdata;
    assign ctrl_o  = irq_ctrl_t'(bank_q.regs[0][CTRL_W-1:0]);
endmodule

// File: rtl/host_regbus_irq.sv
module host_regbus_irq
    import host_regbus_pkg::*;
#(
    parameter int A_W = 4,
    parameter int B_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] req_a_i,
    input  logic [B_W-1:0] req_b_i,
    input  irq_ctrl_t      ctrl_i,
    output logic [1:0]     irq_n_o
);
    typedef struct packed {
        logic [1:0] irq_n;
    } irq_t;

    irq_t irq_d, irq_q;
    logic any_a, any_b;

    always_comb begin
        any_a = |req_a_i;
        any_b = |req_b_i;
        irq_d = irq_q;
        irq_d.irq_n[0] = ctrl_i.quiet0 | ~(any_a | (ctrl_i.merge & any_b));
        irq_d.irq_n[1] = ctrl_i.quiet1 | ctrl_i.merge | ~any_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '{irq_n: 2'b11};
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_n_o = irq_q.irq_n;
endmodule

// File: rtl/host_regbus_slave.sv
module host_regbus_slave
    import host_regbus_pkg::*;
#(
    parameter int NUM_REGS  = 8,
    parameter int ADDR_W    = 5,
    parameter int READY_DLY = 2,
    parameter int A_W       = 4,
    parameter int B_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode32_i,
    input  logic              cs_n_i,
    input  logic              rd_wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic [3:0]        be_n_i,
    output logic [31:0]       rdata_o,
    output logic              rdy_n_o,
    output logic              rdy_oe_o,
    input  logic [A_W-1:0]    req_a_i,
    input  logic [B_W-1:0]    req_b_i,
    output logic [1:0]        irq_n_o
);
    logic [1:0]  sync_q;
    logic        cs_s, rd_s;
    logic        commit, ack;
    logic [31:0] rdata_q;
    irq_ctrl_t   ctrl_w;

    host_regbus_sync #(.WIDTH(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_n_i, rd_wr_i}),
        .q_o   (sync_q)
    );
    assign cs_s = sync_q[1];
    assign rd_s = sync_q[0];

    host_regbus_hs #(.READY_DLY(READY_DLY)) u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s_i   (cs_s),
        .commit_o (commit),
        .ack_o    (ack),
        .rdy_n_o  (rdy_n_o),
        .rdy_oe_o (rdy_oe_o)
    );

    host_regbus_bank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode32_i  (mode32_i),
        .commit_i  (commit),
        .is_read_i (rd_s),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .be_n_i    (be_n_i),
        .rdata_o   (rdata_q),
        .ctrl_o    (ctrl_w)
    );

    host_regbus_irq #(.A_W(A_W), .B_W(B_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_a_i (req_a_i),
        .req_b_i (req_b_i),
        .ctrl_i  (ctrl_w),
        .irq_n_o (irq_n_o)
    );

    assign rdata_o = ack ? rdata_q : '0;
endmodule

// File: rtl/host_regbus_checker.sv
module host_regbus_checker
    import host_regbus_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        rdy_n_o,
    input logic        rdy_oe_o,
    input logic [31:0] rdata_o,
    input logic [1:0]  irq_n_o,
    input irq_ctrl_t   ctrl
);
    a_r3_low_only_when_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_n_o |-> rdy_oe_o);

    a_r3_rise_while_driven: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_n_o) |-> rdy_oe_o);

    a_r3_release_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_oe_o) |-> ($past(rdy_n_o) && $past(rdy_oe_o)));

    a_r6_data_zero_outside: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_n_o |-> (rdata_o == 32'h0));

    a_r6_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n_o && !$past(rdy_n_o)) |-> $stable(rdata_o));

    a_r11_quiet0: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.quiet0 |=> irq_n_o[0]);

    a_r11_quiet1: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.quiet1 |=> irq_n_o[1]);

    a_r10_merge_silences_one: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.merge |=> irq_n_o[1]);
endmodule

bind host_regbus_slave host_regbus_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdy_n_o  (rdy_n_o),
    .rdy_oe_o (rdy_oe_o),
    .rdata_o  (rdata_o),
    .irq_n_o  (irq_n_o),
    .ctrl     (ctrl_w)
);

// File: tb/host_regbus_slave_test.sv
module host_regbus_slave_test;
    localparam int NREG = 8;
    localparam int AW   = 5;
    localparam int DLY  = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mode32;
    logic          cs_n;
    logic          rd_wr;
    logic [AW-1:0] addr;
    logic [31:0]   wdata;
    logic [3:0]    be_n;
    logic [31:0]   rdata_o;
    logic          rdy_n_o;
    logic          rdy_oe_o;
    logic [3:0]    req_a;
    logic [3:0]    req_b;
    logic [1:0]    irq_n_o;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    host_regbus_slave #(.NUM_REGS(NREG), .ADDR_W(AW), .READY_DLY(DLY), .A_W(4), .B_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .mode32_i(mode32), .cs_n_i(cs_n), .rd_wr_i(rd_wr),
        .addr_i(addr), .wdata_i(wdata), .be_n_i(be_n), .rdata_o(rdata_o),
        .rdy_n_o(rdy_n_o), .rdy_oe_o(rdy_oe_o), .req_a_i(req_a), .req_b_i(req_b),
        .irq_n_o(irq_n_o)
    );

    // Behavioural reference model
    logic [31:0] m_mem [NREG];
    logic [31:0] m_rd;
    logic [1:0]  m_irq;
    int          m_ph;
    int          m_cnt;
    bit          cs_pipe[$];
    bit          rd_pipe[$];

    task automatic model_commit(input bit is_rd);
        int          idx;
        logic [3:0]  en;
        logic [31:0] wd;
        logic [31:0] word;
        idx = mode32 ? int'(addr) : int'(addr) / 2;
        if (mode32) begin
            en = ~be_n; wd = wdata;
        end else if (addr[0]) begin
            en = {~be_n[1:0], 2'b00}; wd = {wdata[15:0], 16'h0};
        end else begin
            en = {2'b00, ~be_n[1:0]}; wd = {16'h0, wdata[15:0]};
        end
        if (is_rd) begin
            word = (idx < NREG) ? m_mem[idx] : 32'h0;
            if (mode32)       m_rd = word;
            else if (addr[0]) m_rd = word >> 16;
            else              m_rd = word & 32'h0000_FFFF;
        end else begin
            m_rd = 32'h0;
            if (idx < NREG) begin
                for (int b = 0; b < 4; b++) if (en[b]) m_mem[idx][8*b +: 8] = wd[8*b +: 8];
                if (idx == 0) m_mem[0] = m_mem[0] & 32'h7;
            end
        end
    endtask

    always @(posedge clk) begin
        bit cs_u, rd_u;
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) m_mem[i] = 32'h0;
            m_rd = 32'h0; m_irq = 2'b11; m_ph = 0; m_cnt = 0;
            cs_pipe = '{1'b1, 1'b1};
            rd_pipe = '{1'b1, 1'b1};
        end else begin
            m_irq[0] = !((|req_a) || (m_mem[0][0] && (|req_b))) || m_mem[0][1];
            m_irq[1] = !((|req_b) && !m_mem[0][0]) || m_mem[0][2];
            cs_u = cs_pipe.pop_front(); cs_pipe.push_back(cs_n);
            rd_u = rd_pipe.pop_front(); rd_pipe.push_back(rd_wr);
            case (m_ph)
                0: if (!cs_u) begin m_ph = 1; m_cnt = 0; end
                1: if (m_cnt == DLY - 1) begin m_ph = 2; model_commit(rd_u); end
                   else m_cnt++;
                2: if (cs_u) m_ph = 3;
                default: m_ph = 0;
            endcase
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (rdy_n_o !== (m_ph != 2) || rdy_oe_o !== (m_ph == 2 || m_ph == 3)) begin
                errors++;
                $display("FAIL R2/R3 ready pin: got n=%b oe=%b expected n=%b oe=%b",
                         rdy_n_o, rdy_oe_o, (m_ph != 2), (m_ph == 2 || m_ph == 3));
            end
            if (rdata_o !== ((m_ph == 2) ? m_rd : 32'h0)) begin
                errors++;
                $display("FAIL R6 rdata: got %h expected %h", rdata_o, (m_ph == 2) ? m_rd : 32'h0);
            end
            if (irq_n_o !== m_irq) begin
                errors++;
                $display("FAIL R9/R10/R11 irq: got %b expected %b", irq_n_o, m_irq);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic rd, input logic [AW-1:0] a, input logic [31:0] d,
                          input logic [3:0] ben, output logic [31:0] got);
        int n;
        @(negedge clk);
        rd_wr = rd; addr = a; wdata = d; be_n = ben;
        @(negedge clk);
        cs_n = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (rdy_n_o && n < 40);
        check("R2 ready latency", 32'(n), 32'(3 + DLY));
        got = rdata_o;
        cs_n = 1'b1;
        n = 0;
        do begin
            @(negedge clk); n++;
            if (n == 3) check("R3 driven high cycle", {30'h0, rdy_oe_o, rdy_n_o}, 32'h3);
        end while (rdy_oe_o && n < 40);
        check("R3 release cycle", 32'(n), 32'h4);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] ben);
        logic [31:0] unused_rd;
        access(1'b0, a, d, ben, unused_rd);
        check("R6 write shows no data", unused_rd, 32'h0);
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
        logic [31:0] got;
        access(1'b1, a, 32'h0, 4'hF, got);
        check(req, got, exp);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode32 = 1'b1; cs_n = 1'b1; rd_wr = 1'b1;
        addr = '0; wdata = '0; be_n = 4'hF; req_a = '0; req_b = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rdy_n", {31'h0, rdy_n_o}, 32'h1);
        check("R1 rdy_oe", {31'h0, rdy_oe_o}, 32'h0);
        check("R1 rdata", rdata_o, 32'h0);
        check("R1 irq", {30'h0, irq_n_o}, 32'h3);
        rst_n = 1'b1;
        rd_chk("R1 control reads zero", 5'd0, 32'h0);

        // R4 32-bit full word and lane-masked write
        wr(5'd1, 32'h1122_3344, 4'b0000);
        rd_chk("R4 full word", 5'd1, 32'h1122_3344);
        wr(5'd1, 32'hAABB_CCDD, 4'b1010);
        rd_chk("R4 lanes 0 and 2", 5'd1, 32'h11BB_33DD);
        wr(5'd2, 32'hCAFE_F00D, 4'b0111);
        rd_chk("R4 only lane 3", 5'd2, 32'hCA00_0000);

        // R7 unmapped index
        wr(5'd9, 32'hFFFF_FFFF, 4'b0000);
        rd_chk("R7 unmapped read", 5'd9, 32'h0);
        rd_chk("R7 neighbour intact", 5'd1, 32'h11BB_33DD);

        // R5 16-bit mode
        @(negedge clk); mode32 = 1'b0;
        wr(5'd3, 32'h0000_5566, 4'b1100);
        rd_chk("R5 upper half", 5'd3, 32'h0000_5566);
        rd_chk("R5 lower half", 5'd2, 32'h0000_33DD);
        wr(5'd2, 32'h0000_7788, 4'b0001);
        rd_chk("R5 low byte kept", 5'd2, 32'h0000_77DD);
        rd_chk("R7 unmapped in 16-bit", 5'd20, 32'h0);
        @(negedge clk); mode32 = 1'b1;
        rd_chk("R5 word view", 5'd1, 32'h5566_77DD);

        // R9 / R10 / R11 interrupts
        @(negedge clk); req_a = 4'b0100; req_b = 4'b0000;
        repeat (2) @(negedge clk);
        check("R9 group A", {30'h0, irq_n_o}, 32'h2);
        req_a = 4'b0000; req_b = 4'b0010;
        repeat (2) @(negedge clk);
        check("R10 group B", {30'h0, irq_n_o}, 32'h1);
        wr(5'd0, 32'h0000_0001, 4'b0000);
        repeat (2) @(negedge clk);
        check("R9 merged B on output 0", {30'h0, irq_n_o}, 32'h2);
        wr(5'd0, 32'h0000_0003, 4'b0000);
        repeat (2) @(negedge clk);
        check("R11 quiet0 with merge", {30'h0, irq_n_o}, 32'h3);
        req_a = 4'b1000; req_b = 4'b0001;
        wr(5'd0, 32'h0000_0004, 4'b0000);
        repeat (2) @(negedge clk);
        check("R11 quiet1", {30'h0, irq_n_o}, 32'h2);
        wr(5'd0, 32'hFFFF_FFFF, 4'b0000);
        rd_chk("R8 control mask", 5'd0, 32'h0000_0007);
        check("R11 both quiet", {30'h0, irq_n_o}, 32'h3);
        wr(5'd0, 32'h0, 4'b0000);
        repeat (3) @(negedge clk);
        check("R10 unmerged both active", {30'h0, irq_n_o}, 32'h0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule